// File: doc/BRIEF.md
# Integer Shifter with Carry Out

This unit performs the integer shift operations of a processor datapath: logical left, logical right and arithmetic right. Each works either on the low half of the operand (word mode, 32 bits by default) or on the full operand (doubleword mode, 64 bits by default). The shift count comes from one of two places. The register form takes a count field that is one bit wider than the operand needs, and that top "range" bit saturates the shift. The immediate form takes a count of exactly the needed width and has no range bit.

For arithmetic right shifts the unit also produces a carry flag. The flag is raised only when the source is negative and at least one 1 bit falls off the low end; a saturated arithmetic shift of a negative value always raises it. Word results are brought back to the full width: logical results are zero-extended and arithmetic results are sign-extended. An issue stage presents one operation per cycle with a valid strobe, and the result and carry appear registered one cycle later.

Top module: `shift_unit`

## Requirements
- R1: In doubleword mode (`dword`=1) with the register count (`amt_sel`=0), a logical shift (`op`=0 left, `op`=1 right) gives zero when `amt_reg[6]` is 1; otherwise it shifts by `amt_reg[5:0]`, filling with zeros.
- R2: In word mode (`dword`=0) with the register count, a logical shift acts on `src[31:0]`. It gives zero when `amt_reg[5]` is 1, otherwise it shifts by `amt_reg[4:0]`. Result bits 63:32 are always zero.
- R3: A word arithmetic right shift (`op`=2) with `amt_reg[5]`=1 gives all 64 bits equal to `src[31]`, and carry equals `src[31]`.
- R4: A doubleword arithmetic right shift with `amt_reg[6]`=1 gives all 64 bits equal to `src[63]`, and carry equals `src[63]`.
- R5: An arithmetic right shift inside the range sets carry exactly when the source sign bit (`src[31]` in word mode, `src[63]` in doubleword mode) is 1 and at least one 1 bit is shifted out. The word result is the 32-bit arithmetic shift, sign-extended from its bit 31.
- R6: An effective count of zero, with no range bit set, passes the source through and clears carry. In word mode the 32-bit source is zero-extended for logical ops and sign-extended for the arithmetic op.
- R7: With `amt_sel`=1 the count is `amt_imm[4:0]` in word mode and `amt_imm[5:0]` in doubleword mode, there is no range bit, and `amt_reg` has no effect.
- R8: Logical shifts (`op`=0 or 1) never set carry.
- R9: The reserved operation code `op`=3 gives a zero result and a clear carry.
- R10: `out_valid` is `in_valid` delayed by one cycle. `result` and `carry` update only in the cycle after `in_valid` is high and otherwise hold their value.
- R11: After reset, `out_valid`, `result` and `carry` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 reserved |
| dword | input | 1 | 1 selects doubleword mode, 0 word mode |
| amt_sel | input | 1 | 0 register count, 1 immediate count |
| amt_reg | input | 7 | Register count with range bit |
| amt_imm | input | 6 | Immediate count |
| src | input | 64 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Shift result |
| carry | output | 1 | Arithmetic-shift carry |

## Verification
The bench builds the unit with its default width of 64. That default puts the word range bit at position 5 and the doubleword range bit at position 6, so both saturation paths can be reached, along with counts of 31 and 63 on either side of them. An independent reference computed with language shift operators drives every comparison. Negative sources are paired with shifts that drop only zeros and with shifts that drop a set bit, which separates the two carry conditions.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [1:0] {
    SH_LL   = 2'd0,
    SH_RL   = 2'd1,
    SH_RA   = 2'd2,
    SH_RSVD = 2'd3
  } shift_op_e;
endpackage

// File: rtl/shift_amount_sel.sv
// Chooses the effective count and saturation flag for the active mode.
module shift_amount_sel #(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW)
) (
  input  logic           dword,
  input  logic           amt_sel,
  input  logic [SHW:0]   amt_reg,
  input  logic [SHW-1:0] amt_imm,
  output logic [SHW-1:0] cnt,
  output logic           over
);
  always_comb begin
    if (dword) begin
      cnt  = amt_sel ? amt_imm : amt_reg[SHW-1:0];
      over = amt_sel ? 1'b0 : amt_reg[SHW];
    end else begin
      cnt  = {1'b0, (amt_sel ? amt_imm[SHW-2:0] : amt_reg[SHW-2:0])};
      over = amt_sel ? 1'b0 : amt_reg[SHW-1];
    end
  end
endmodule

// File: rtl/shift_barrel.sv
// Logarithmic right shifter with a fill bit; left shifts reuse it by reversal.
module shift_barrel #(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  din,
  input  logic [SHW-1:0] cnt,
  input  logic           fill,
  input  logic           left,
  output logic [DW-1:0]  dout
);
  logic [DW-1:0] din_rev;
  logic [DW-1:0] stage_in;
  logic [DW-1:0] stage [SHW+1];
  logic [DW-1:0] out_rev;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign din_rev[i] = din[DW-1-i];
    assign out_rev[i] = stage[SHW][DW-1-i];
  end

  assign stage_in = left ? din_rev : din;
  assign stage[0] = stage_in;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = cnt[s] ? {{STEP{fill}}, stage[s][DW-1:STEP]} : stage[s];
  end

  assign dout = left ? out_rev : stage[SHW];
endmodule

// File: rtl/shift_lost_bits.sv
// Reports whether any set bit sits below the shift count.
module shift_lost_bits #(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  din,
  input  logic [SHW-1:0] cnt,
  output logic           lost
);
  logic [DW-1:0] below;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    localparam logic [SHW-1:0] IDX = SHW'(i);
    assign below[i] = (IDX < cnt) & din[i];
  end

  assign lost = |below;
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     op,
  input  logic           dword,
  input  logic           amt_sel,
  input  logic [SHW:0]   amt_reg,
  input  logic [SHW-1:0] amt_imm,
  input  logic [DW-1:0]  src,
  output logic           out_valid,
  output logic [DW-1:0]  result,
  output logic           carry
);
  shift_op_e     op_e;
  logic [SHW-1:0] cnt;
  logic          over;
  logic          is_ra;
  logic          is_left;
  logic          sign;
  logic          fill;
  logic [DW-1:0] operand;
  logic [DW-1:0] shifted;
  logic          lost;
  logic [DW-1:0] res_d;
  logic          carry_d;
  logic          valid_q;
  logic [DW-1:0] res_q;
  logic          carry_q;

  assign op_e    = shift_op_e'(op);
  assign is_ra   = (op_e == SH_RA);
  assign is_left = (op_e == SH_LL);
  assign sign    = dword ? src[DW-1] : src[HW-1];
  assign fill    = is_ra & sign;
  assign operand = dword ? src : {{HW{fill}}, src[HW-1:0]};

  shift_amount_sel #(.DW(DW)) u_amt (
    .dword   (dword),
    .amt_sel (amt_sel),
    .amt_reg (amt_reg),
    .amt_imm (amt_imm),
    .cnt     (cnt),
    .over    (over)
  );

  shift_barrel #(.DW(DW)) u_barrel (
    .din  (operand),
    .cnt  (cnt),
    .fill (fill),
    .left (is_left),
    .dout (shifted)
  );

  shift_lost_bits #(.DW(DW)) u_lost (
    .din  (operand),
    .cnt  (cnt),
    .lost (lost)
  );

  // Result shaping after the shifter: saturation, word extension, reserved code.
  always_comb begin
    res_d   = '0;
    carry_d = 1'b0;
    unique case (op_e)
      SH_LL, SH_RL: begin
        if (!over) begin
          res_d = dword ? shifted : {{HW{1'b0}}, shifted[HW-1:0]};
        end
      end
      SH_RA: begin
        res_d   = over ? {DW{sign}} : shifted;
        carry_d = sign & (over | lost);
      end
      default: begin
        res_d   = '0;
        carry_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_d;
        carry_q <= carry_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign carry     = carry_q;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [1:0]     op,
  input logic           dword,
  input logic           amt_sel,
  input logic [SHW:0]   amt_reg,
  input logic [SHW-1:0] amt_imm,
  input logic [DW-1:0]  src,
  input logic           out_valid,
  input logic [DW-1:0]  result,
  input logic           carry
);
  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry) && !out_valid));

  // R8
  logical_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 2'd0 || op == 2'd1)) |=> !carry);

  // R2
  word_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dword && op != 2'd2) |=> (result[DW-1:HW] == '0));

  // R5
  word_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dword && op == 2'd2) |=> (result[DW-1:HW] == {HW{result[HW-1]}}));

  // R3
  word_sat_ra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dword && op == 2'd2 && !amt_sel && amt_reg[SHW-1])
      |=> (carry == $past(src[HW-1]) && result == {DW{$past(src[HW-1])}}));

  // R4
  dword_sat_ra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dword && op == 2'd2 && !amt_sel && amt_reg[SHW])
      |=> (carry == $past(src[DW-1]) && result == {DW{$past(src[DW-1])}}));

  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dword && amt_sel && amt_imm == '0 && op != 2'd3)
      |=> (result == $past(src) && !carry));

  // R9
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> (result == '0 && !carry));
endmodule

bind shift_unit shift_unit_chk #(.DW(DW)) u_shift_unit_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .dword     (dword),
  .amt_sel   (amt_sel),
  .amt_reg   (amt_reg),
  .amt_imm   (amt_imm),
  .src       (src),
  .out_valid (out_valid),
  .result    (result),
  .carry     (carry)
);

// File: tb/test_shift_unit.sv
`timescale 1ns/1ps
module test_shift_unit;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        dword = 1'b0;
  logic        amt_sel = 1'b0;
  logic [6:0]  amt_reg = '0;
  logic [5:0]  amt_imm = '0;
  logic [63:0] src = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shift_unit #(.DW(DW)) i_shift_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
    .dword (dword), .amt_sel (amt_sel), .amt_reg (amt_reg),
    .amt_imm (amt_imm), .src (src), .out_valid (out_valid),
    .result (result), .carry (carry)
  );

  // Reference model written from the requirements.
  function automatic void ref_shift(input logic [1:0] o, input logic d,
      input logic sel, input logic [6:0] ra, input logic [5:0] im,
      input logic [63:0] s, output logic [63:0] r, output logic c);
    int cnt;
    logic rng;
    logic sg;
    logic signed [63:0] ss;
    logic signed [31:0] sw;
    logic [31:0] w;
    logic [63:0] lowm;
    r = '0; c = 1'b0;
    if (d) begin
      cnt = sel ? int'(im) : int'(ra[5:0]);
      rng = sel ? 1'b0 : ra[6];
      sg  = s[63];
      ss  = s;
      lowm = (64'd1 << cnt) - 64'd1;
      case (o)
        2'd0: r = rng ? 64'd0 : (s << cnt);
        2'd1: r = rng ? 64'd0 : (s >> cnt);
        2'd2: begin
          r = rng ? {64{sg}} : 64'(ss >>> cnt);
          c = sg && (rng || ((s & lowm) != 0));
        end
        default: r = '0;
      endcase
    end else begin
      cnt = sel ? int'(im[4:0]) : int'(ra[4:0]);
      rng = sel ? 1'b0 : ra[5];
      w   = s[31:0];
      sw  = w;
      sg  = w[31];
      lowm = (64'd1 << cnt) - 64'd1;
      case (o)
        2'd0: begin w = w << cnt; r = rng ? 64'd0 : {32'd0, w}; end
        2'd1: begin w = w >> cnt; r = rng ? 64'd0 : {32'd0, w}; end
        2'd2: begin
          w = 32'(sw >>> cnt);
          r = rng ? {64{sg}} : {{32{w[31]}}, w};
          c = sg && (rng || (({32'd0, s[31:0]} & lowm) != 0));
        end
        default: r = '0;
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] got_r,
      input logic got_c, input logic [63:0] exp_r, input logic exp_c);
    checks++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      failures++;
      $display("FAIL %s result=%h carry=%b expected result=%h carry=%b",
               tag, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] o, input logic d,
      input logic sel, input logic [6:0] ra, input logic [5:0] im,
      input logic [63:0] s);
    logic [63:0] er;
    logic ec;
    @(negedge clk);
    op = o; dword = d; amt_sel = sel; amt_reg = ra; amt_imm = im; src = s;
    in_valid = 1'b1;
    ref_shift(o, d, sel, ra, im, s, er, ec);
    @(posedge clk); #1;
    check(tag, result, carry, er, ec);
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s out_valid=%b expected 1", tag, out_valid);
    end
  endtask

  task automatic t_reset();
    // R11
    check("R11", result, carry, 64'd0, 1'b0);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 out_valid=%b expected 0", out_valid);
    end
  endtask

  task automatic t_dword_logical();
    run_op("R1", 2'd0, 1'b1, 1'b0, 7'd4,  6'd0, 64'h8000_0000_0000_00F1);
    run_op("R1", 2'd1, 1'b1, 1'b0, 7'd63, 6'd0, 64'h8000_0000_0000_0000);
    run_op("R1", 2'd0, 1'b1, 1'b0, 7'd64, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R1", 2'd1, 1'b1, 1'b0, 7'd100, 6'd0, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_word_logical();
    run_op("R2", 2'd0, 1'b0, 1'b0, 7'd8,  6'd0, 64'hDEAD_BEEF_1234_5678);
    run_op("R2", 2'd1, 1'b0, 1'b0, 7'd31, 6'd0, 64'hFFFF_FFFF_8000_0000);
    run_op("R2", 2'd0, 1'b0, 1'b0, 7'd32, 6'd0, 64'h0000_0000_FFFF_FFFF);
    run_op("R8", 2'd1, 1'b0, 1'b0, 7'd4,  6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_saturated_ra();
    run_op("R3", 2'd2, 1'b0, 1'b0, 7'd32, 6'd0, 64'h0000_0000_8000_0000);
    run_op("R3", 2'd2, 1'b0, 1'b0, 7'd33, 6'd0, 64'hFFFF_FFFF_7FFF_FFFF);
    run_op("R4", 2'd2, 1'b1, 1'b0, 7'd64, 6'd0, 64'h8000_0000_0000_0000);
    run_op("R4", 2'd2, 1'b1, 1'b0, 7'd70, 6'd0, 64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_ra_carry();
    run_op("R5", 2'd2, 1'b1, 1'b0, 7'd4,  6'd0, 64'hF000_0000_0000_0010);
    run_op("R5", 2'd2, 1'b1, 1'b0, 7'd5,  6'd0, 64'hF000_0000_0000_0010);
    run_op("R5", 2'd2, 1'b0, 1'b0, 7'd8,  6'd0, 64'h0000_0000_8000_0100);
    run_op("R5", 2'd2, 1'b0, 1'b0, 7'd9,  6'd0, 64'h0000_0000_8000_0100);
    run_op("R5", 2'd2, 1'b0, 1'b0, 7'd3,  6'd0, 64'hFFFF_FFFF_7FFF_FFFF);
    run_op("R5", 2'd2, 1'b1, 1'b0, 7'd63, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_zero_count();
    run_op("R6", 2'd2, 1'b1, 1'b0, 7'd0, 6'd0, 64'hF000_0000_0000_0001);
    run_op("R6", 2'd2, 1'b0, 1'b0, 7'd0, 6'd0, 64'h0000_0000_8000_0001);
    run_op("R6", 2'd1, 1'b0, 1'b1, 7'd5, 6'd0, 64'hABCD_0000_8000_0001);
  endtask

  task automatic t_immediate();
    // register count saturating but unused: immediate rules
    run_op("R7", 2'd0, 1'b1, 1'b1, 7'h7F, 6'd40, 64'h0000_0000_0000_00FF);
    run_op("R7", 2'd2, 1'b0, 1'b1, 7'h7F, 6'd36, 64'h0000_0000_8000_0030);
    run_op("R7", 2'd1, 1'b0, 1'b1, 7'd0,  6'd31, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_reserved();
    run_op("R9", 2'd3, 1'b1, 1'b0, 7'd3, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R9", 2'd3, 1'b0, 1'b1, 7'd0, 6'd2, 64'h8000_0000_8000_0003);
  endtask

  task automatic t_hold();
    logic [63:0] er;
    logic ec;
    run_op("R10", 2'd2, 1'b1, 1'b0, 7'd1, 6'd0, 64'h8000_0000_0000_0001);
    ref_shift(2'd2, 1'b1, 1'b0, 7'd1, 6'd0, 64'h8000_0000_0000_0001, er, ec);
    @(negedge clk);
    in_valid = 1'b0; op = 2'd0; src = 64'h5555_5555_5555_5555; amt_reg = 7'd2;
    @(posedge clk); #1;
    check("R10", result, carry, er, ec);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_dword_logical();
    t_word_logical();
    t_saturated_ra();
    t_ra_carry();
    t_zero_count();
    t_immediate();
    t_reserved();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule